// File: doc/BRIEF.md
# Reset Source Status and Control Registers

This block is the software-facing register pair of a chip reset controller. A status register tells software which reset source the controller acknowledged most recently. It also holds the level of a boot-configuration pin, which is sampled as the system reset is released. A control register lets software start a system reset, enable checkstop resets for each of two cores, and lock out further software resets.

Each reset source drives one request line into the block. These sources are low voltage, the external pin, loss of PLL lock, loss of clock, the watchdog, the two core checkstops and the block's own software request. In any cycle, the block acknowledges at most one request, and it picks that request by a fixed priority.

The block has two reset inputs that follow different rules. The power-on reset returns every field to its initial value. The system reset only clears the pending software pulse and marks the point at which the boot pin is sampled. Status flags, checkstop enables and the lock bit survive a system reset.

Top module: `rst_status_ctrl`

## Requirements
- R1: When the power-on reset is released, the status register reads 0x001 (power-on flag set, all other flags and the boot bit 0). The control register reads 0x0000C000, swRstReq is 0 and chkEnOut is 2'b11.
- R2: Status bits 1..6 are source flags, in this order: external, PLL lock lost, clock lost, watchdog, checkstop, software. After a request is acknowledged, only the flag of that source is 1. Simultaneous requests are acknowledged by priority: low voltage, then external, then lock loss, then clock loss, then watchdog, then checkstop, then software.
- R3: Status bit 0 is the power-on flag. A low-voltage request sets it. An external-pin acknowledgement leaves it unchanged, and any other acknowledged source clears it.
- R4: A checkstop request from core k is acknowledged only while enable bit k is 1. A request from a disabled core leaves every status flag unchanged.
- R5: Writing 1 to control bit 31 makes swRstReq high for exactly the one cycle after the write edge. At the following edge, the software flag is acknowledged. Bit 31 always reads 0, and writing 0 to it requests nothing.
- R6: Control bits 14 and 15 are the checkstop enables for cores 0 and 1, and they drive chkEnOut. Software can write them. Power-on reset and a low-voltage acknowledgement set both to 1. A system reset leaves them unchanged.
- R7: Control bit 7 is a lock. Writing 1 sets it. Writes of 0 are ignored. Only power-on reset or a low-voltage acknowledgement clears it.
- R8: While the lock is 1, a write of 1 to bit 31 produces no pulse and no software acknowledgement.
- R9: Status bit 8 takes the value of bootPin at the first clock edge after sysRst_n rises, and it holds that value at all other times.
- R10: The status register is at offset 0x0C and the control register at 0x10. Unlisted bits read 0, other offsets read 0, and writes to other offsets have no effect.
- R11: Register writes are ignored while sysRst_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRst_n | input | 1 | Power-on reset, asynchronous, active low |
| sysRst_n | input | 1 | System reset, active low |
| lvdReq | input | 1 | Low-voltage reset request |
| extReq | input | 1 | External pin reset request |
| lolReq | input | 1 | PLL lock lost reset request |
| locReq | input | 1 | Clock lost reset request |
| wdgReq | input | 1 | Watchdog reset request |
| chkReq | input | 2 | Per-core checkstop reset requests |
| bootPin | input | 1 | Boot-configuration pin |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 32 | Read data, combinational |
| swRstReq | output | 1 | Software system reset pulse |
| chkEnOut | output | 2 | Per-core checkstop enables |

## Verification
The bench checks the power-on flag across an external reset and across another source. A design that cleared the flag on every acknowledgement would lose it after the external reset. The bench also fires simultaneous requests to confirm the priority: a wrong order would set a lower-ranked flag, or more than one. A checkstop request from a disabled core, and a software trigger written while the lock is set, must both leave the status unchanged. A leaky gate would show up as a stray checkstop or software flag. Finally, the bench passes through a system reset and writes a 0 to the lock bit. The enables and the lock must survive, and the boot bit must be re-sampled only when the reset is released.

// File: rtl/rst_status_pkg.sv
`timescale 1ns/1ps
package rst_status_pkg;
  localparam int NSRC = 7;
  localparam int SRC_LVD = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_LOL = 2;
  localparam int SRC_LOC = 3;
  localparam int SRC_WDG = 4;
  localparam int SRC_CHK = 5;
  localparam int SRC_SW  = 6;

  localparam int ST_POR_BIT  = 0;
  localparam int ST_SRC_LSB  = 1;
  localparam int ST_BOOT_BIT = 8;

  localparam int CTL_SSR_BIT  = 31;
  localparam int CTL_CRE_LSB  = 14;
  localparam int CTL_LOCK_BIT = 7;

  typedef struct packed {
    logic            ctlWr;
    logic            swFire;
    logic            bootCap;
    logic            anyAck;
    logic [NSRC-1:0] ackVec;
  } strobe_t;
endpackage

// File: rtl/rst_status_ctl.sv
`timescale 1ns/1ps
module rst_status_ctl
  import rst_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCORE  = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              sysRst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              lvdReq,
  input  logic              extReq,
  input  logic              lolReq,
  input  logic              locReq,
  input  logic              wdgReq,
  input  logic [NCORE-1:0]  chkReq,
  input  logic [NCORE-1:0]  chkEn,
  input  logic              lockQ,
  output strobe_t           strb,
  output logic              swPulse
);
  logic            ctlHit;
  logic            swFire;
  logic            sysRstQ;
  logic [NSRC-1:0] reqVec;
  logic [NSRC-1:0] ackVec;

  assign ctlHit = wrEn && sysRst_n && (wrAddr == CTRL_OFS);
  assign swFire = ctlHit && wrData[CTL_SSR_BIT] && !lockQ;

  always_comb begin
    reqVec          = '0;
    reqVec[SRC_LVD] = lvdReq;
    reqVec[SRC_EXT] = extReq;
    reqVec[SRC_LOL] = lolReq;
    reqVec[SRC_LOC] = locReq;
    reqVec[SRC_WDG] = wdgReq;
    reqVec[SRC_CHK] = |(chkReq & chkEn);
    reqVec[SRC_SW]  = swPulse;
  end

  // lowest index has highest priority
  always_comb begin
    ackVec = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (reqVec[i]) begin
        ackVec    = '0;
        ackVec[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      sysRstQ <= 1'b0;
      swPulse <= 1'b0;
    end else begin
      sysRstQ <= sysRst_n;
      swPulse <= sysRst_n ? swFire : 1'b0;
    end
  end

  always_comb begin
    strb.ctlWr   = ctlHit;
    strb.swFire  = swFire;
    strb.bootCap = sysRst_n && !sysRstQ;
    strb.anyAck  = |reqVec;
    strb.ackVec  = ackVec;
  end

  p_sw_single_r5: assert property (@(posedge clk) disable iff (!porRst_n)
    swPulse |=> !swPulse);
  p_lock_blocks_sw_r8: assert property (@(posedge clk) disable iff (!porRst_n)
    (ctlHit && lockQ) |=> !swPulse);
endmodule

// File: rtl/rst_status_dp.sv
`timescale 1ns/1ps
module rst_status_dp
  import rst_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCORE  = 2,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              bootPin,
  output logic [DATA_W-1:0] rdData,
  output logic [NCORE-1:0]  chkEn,
  output logic              lockQ
);
  logic              porFlag;
  logic [NSRC-1:1]   srcFlags;
  logic              bootReg;
  logic [DATA_W-1:0] stWord;
  logic [DATA_W-1:0] ctWord;

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      porFlag  <= 1'b1;
      srcFlags <= '0;
    end else if (strb.ackVec[SRC_LVD]) begin
      porFlag  <= 1'b1;
      srcFlags <= '0;
    end else if (strb.anyAck) begin
      srcFlags <= strb.ackVec[NSRC-1:1];
      if (!strb.ackVec[SRC_EXT]) porFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n) begin
      chkEn <= '1;
      lockQ <= 1'b0;
    end else if (strb.ackVec[SRC_LVD]) begin
      chkEn <= '1;
      lockQ <= 1'b0;
    end else if (strb.ctlWr) begin
      chkEn <= wrData[CTL_CRE_LSB +: NCORE];
      lockQ <= lockQ | wrData[CTL_LOCK_BIT];
    end
  end

  always_ff @(posedge clk or negedge porRst_n) begin
    if (!porRst_n)         bootReg <= 1'b0;
    else if (strb.bootCap) bootReg <= bootPin;
  end

  always_comb begin
    stWord                              = '0;
    stWord[ST_POR_BIT]                  = porFlag;
    stWord[ST_SRC_LSB +: NSRC-1]        = srcFlags;
    stWord[ST_BOOT_BIT]                 = bootReg;
    ctWord                              = '0;
    ctWord[CTL_CRE_LSB +: NCORE]        = chkEn;
    ctWord[CTL_LOCK_BIT]                = lockQ;
    if (rdAddr == STAT_OFS)      rdData = stWord;
    else if (rdAddr == CTRL_OFS) rdData = ctWord;
    else                         rdData = '0;
  end

  p_one_src_r2: assert property (@(posedge clk) disable iff (!porRst_n)
    $onehot0(srcFlags));
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!porRst_n)
    (lockQ && !strb.ackVec[SRC_LVD]) |=> lockQ);
  p_cre_hold_r6: assert property (@(posedge clk) disable iff (!porRst_n)
    (!strb.ctlWr && !strb.ackVec[SRC_LVD]) |=> $stable(chkEn));
  p_chk_enabled_r4: assert property (@(posedge clk) disable iff (!porRst_n)
    strb.ackVec[SRC_CHK] |-> (chkEn != '0));
  p_boot_hold_r9: assert property (@(posedge clk) disable iff (!porRst_n)
    !strb.bootCap |=> $stable(bootReg));
endmodule

// File: rtl/rst_status_ctrl.sv
`timescale 1ns/1ps
module rst_status_ctrl
  import rst_status_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int NCORE  = 2,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h10
) (
  input  logic              clk,
  input  logic              porRst_n,
  input  logic              sysRst_n,
  input  logic              lvdReq,
  input  logic              extReq,
  input  logic              lolReq,
  input  logic              locReq,
  input  logic              wdgReq,
  input  logic [NCORE-1:0]  chkReq,
  input  logic              bootPin,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              swRstReq,
  output logic [NCORE-1:0]  chkEnOut
);
  strobe_t    strb;
  logic [NCORE-1:0] chkEn;
  logic       lockQ;

  rst_status_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCORE(NCORE), .CTRL_OFS(CTRL_OFS)) u_ctl (
    .clk(clk), .porRst_n(porRst_n), .sysRst_n(sysRst_n),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .lvdReq(lvdReq), .extReq(extReq), .lolReq(lolReq), .locReq(locReq),
    .wdgReq(wdgReq), .chkReq(chkReq), .chkEn(chkEn), .lockQ(lockQ),
    .strb(strb), .swPulse(swRstReq)
  );

  rst_status_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCORE(NCORE),
                  .STAT_OFS(STAT_OFS), .CTRL_OFS(CTRL_OFS)) u_dp (
    .clk(clk), .porRst_n(porRst_n), .strb(strb), .wrData(wrData),
    .rdAddr(rdAddr), .bootPin(bootPin), .rdData(rdData),
    .chkEn(chkEn), .lockQ(lockQ)
  );

  assign chkEnOut = chkEn;
endmodule

// File: tb/rst_status_ctrl_tb.sv
`timescale 1ns/1ps
module rst_status_ctrl_tb;
  logic        clk = 1'b0;
  logic        porRst_n, sysRst_n;
  logic        lvdReq, extReq, lolReq, locReq, wdgReq;
  logic [1:0]  chkReq;
  logic        bootPin, wrEn;
  logic [7:0]  wrAddr, rdAddr;
  logic [31:0] wrData, rdData;
  logic        swRstReq;
  logic [1:0]  chkEnOut;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string       req;
    logic [31:0] st;
    logic [31:0] ct;
    logic        sw;
    logic [1:0]  ce;
  } item_t;
  item_t q[$];

  // model
  logic       mPor, mBoot, mLock, mSw;
  logic [5:0] mSrc;
  logic [1:0] mCre;

  always #2 clk = ~clk;

  rst_status_ctrl u_dut (
    .clk(clk), .porRst_n(porRst_n), .sysRst_n(sysRst_n),
    .lvdReq(lvdReq), .extReq(extReq), .lolReq(lolReq), .locReq(locReq),
    .wdgReq(wdgReq), .chkReq(chkReq), .bootPin(bootPin),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .swRstReq(swRstReq), .chkEnOut(chkEnOut)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push(input string req);
    item_t it;
    it.req = req;
    it.st  = {23'b0, mBoot, 1'b0, mSrc, mPor};
    it.ct  = (32'(mCre) << 14) | (32'(mLock) << 7);
    it.sw  = mSw;
    it.ce  = mCre;
    q.push_back(it);
  endtask

  task automatic clearIn();
    lvdReq = 0; extReq = 0; lolReq = 0; locReq = 0; wdgReq = 0;
    chkReq = 2'b00; wrEn = 0; wrAddr = 8'h00; wrData = 32'h0;
  endtask

  // inputs already driven at a negedge; expected values reflect the next edge
  task automatic cycle(input string req);
    @(posedge clk);
    push(req);
    @(negedge clk);
    clearIn();
  endtask

  task automatic wrCtl(input logic [31:0] d);
    wrEn = 1; wrAddr = 8'h10; wrData = d;
  endtask

  // monitor
  initial begin
    rdAddr = 8'h00;
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        rdAddr = 8'h0C; #0.4;
        check(it.req, "status", rdData, it.st);
        rdAddr = 8'h10; #0.4;
        check(it.req, "control", rdData, it.ct);
        rdAddr = 8'h20; #0.4;
        check("R10", "unmapped", rdData, 32'h0);
        check(it.req, "swRstReq", 32'(swRstReq), 32'(it.sw));
        check(it.req, "chkEnOut", 32'(chkEnOut), 32'(it.ce));
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    clearIn();
    porRst_n = 0; sysRst_n = 0; bootPin = 1;
    mPor = 1; mSrc = 0; mBoot = 0; mLock = 0; mSw = 0; mCre = 2'b11;
    repeat (3) @(negedge clk);
    porRst_n = 1;
    cycle("R1");
    // R11: write while system reset held
    wrCtl(32'h0000_0080);
    cycle("R11");
    sysRst_n = 1; mBoot = 1;
    cycle("R9");
    bootPin = 0;
    cycle("R9");
    // R10: write to another offset
    wrEn = 1; wrAddr = 8'h0C; wrData = 32'hFFFF_FFFF;
    cycle("R10");
    extReq = 1; mSrc = 6'b000001;
    cycle("R3");
    wdgReq = 1; mSrc = 6'b001000; mPor = 0;
    cycle("R3");
    extReq = 1; mSrc = 6'b000001;
    cycle("R3");
    lolReq = 1; locReq = 1; wdgReq = 1; mSrc = 6'b000010;
    cycle("R2");
    locReq = 1; wdgReq = 1; chkReq = 2'b11; mSrc = 6'b000100;
    cycle("R2");
    lvdReq = 1; extReq = 1; mPor = 1; mSrc = 0;
    cycle("R2");
    wrCtl(32'h0000_0000); mCre = 2'b00;
    cycle("R6");
    chkReq = 2'b01;
    cycle("R4");
    wrCtl(32'h0000_4000); mCre = 2'b01;
    cycle("R6");
    chkReq = 2'b10;
    cycle("R4");
    chkReq = 2'b01; mSrc = 6'b010000; mPor = 0;
    cycle("R4");
    wrCtl(32'h8000_4000); mSw = 1;
    cycle("R5");
    mSw = 0; mSrc = 6'b100000;
    cycle("R5");
    wdgReq = 1; mSrc = 6'b001000;
    cycle("R5");
    wrCtl(32'h0000_4080); mLock = 1;
    cycle("R7");
    wrCtl(32'h8000_4000);
    cycle("R8");
    cycle("R8");
    wrCtl(32'h0000_C000); mCre = 2'b11;
    cycle("R7");
    sysRst_n = 0; bootPin = 0;
    wrCtl(32'h0000_0000);
    cycle("R11");
    cycle("R6");
    sysRst_n = 1; mBoot = 0;
    cycle("R9");
    lvdReq = 1; mPor = 1; mSrc = 0; mLock = 0; mCre = 2'b11;
    cycle("R7");
    wrCtl(32'h8000_C000); mSw = 1;
    cycle("R8");
    mSw = 0; mSrc = 6'b100000; mPor = 0;
    cycle("R5");
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule